// File: doc/BRIEF.md
# Rotated Complex Integer Dot-Product Accumulator

This block is a vector datapath. It splits two source vectors into packed signed complex numbers. In each complex number the real part sits in the even element and the imaginary part in the odd element. It takes the real or the imaginary part of each complex product and adds it into a wide accumulator lane. Each accumulator lane is four times the element width. It lies over four source elements, which is two complex numbers. Both of those products are added into that lane, pair 0 first and pair 1 second.

Before the multiply, the second operand is turned by 0, 90, 180 or 270 degrees. The turn is made by choosing which element of each pair is used, and by choosing whether the second product is added or subtracted. A two-bit size code picks the mode. One mode uses 8-bit elements and 32-bit lanes. The other uses 16-bit elements and 64-bit lanes. Size codes with the upper bit clear are flagged as undefined, and in that case the accumulator passes through unchanged. The result is registered, and it appears one clock after a valid request.

Top module: `cdot_accum`

## Requirements
- R1: When size_code[0] is 0, elements are 8-bit signed and lanes are 32 bits wide (VW/32 lanes). When size_code[0] is 1, elements are 16-bit signed and lanes are 64 bits wide (VW/64 lanes).
- R2: Lane k uses narrow elements 4k to 4k+3 of each source vector. Element j sits at bits [j*EW +: EW]. The even element of a pair is the real part and the odd element is the imaginary part.
- R3: For the pair at elements 2p and 2p+1 of the second source, term A is element 2p+rot[0] and term B is element 2p+(1-rot[0]).
- R4: When rot[1] equals rot[0] (codes 00 and 11), each step computes acc + re*A - im*B. Otherwise (codes 01 and 10) each step computes acc + re*A + im*B.
- R5: Pair 0 of a lane is applied first, then pair 1. Both update the same running sum, which starts from that lane of acc_in.
- R6: Products are formed at full precision from the sign-extended elements. The sum wraps modulo 2^(lane width), with no saturation.
- R7: When size_code[1] is 0, the result carries out_undef=1 and acc_out equals acc_in unchanged. When size_code[1] is 1, out_undef=0.
- R8: out_valid is high in the cycle after a cycle with in_valid high, and only then. acc_out and out_undef change only on a valid request.
- R9: A synchronous active-high reset clears out_valid, out_undef and acc_out to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| size_code | input | 2 | Bit 1 set = defined. Bit 0 selects 16-bit elements and 64-bit lanes. |
| rot | input | 2 | Rotation: 00=0, 01=90, 10=180, 11=270 degrees |
| src_n | input | VW | First source vector (packed complex) |
| src_m | input | VW | Second source vector (rotated operand) |
| acc_in | input | VW | Accumulator vector in |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_undef | output | 1 | Result came from an undefined size code |
| acc_out | output | VW | Updated accumulator vector |

## Verification
The clocked assertions assume that in_valid, size_code and acc_in are stable around the sampling edge. They also assume that reset is held for at least one edge before the first request. The bench drives every input on the falling edge and releases reset before it issues anything, so both assumptions hold. The assertion in each lane takes the source and accumulator slices as settled combinational values. Random requests draw all four rotations and all four size codes, so undefined codes are exercised as legal inputs and not treated as errors.

// File: rtl/cdot_pkg.sv
package cdot_pkg;

    localparam int unsigned VEC_W    = 128;
    localparam int unsigned NARROW_E = 8;
    localparam int unsigned WIDE_E   = 16;

    typedef enum logic [1:0] {
        ROT_0   = 2'b00,
        ROT_90  = 2'b01,
        ROT_180 = 2'b10,
        ROT_270 = 2'b11
    } rot_e;

    typedef struct packed {
        logic undef;
        logic wide;
        rot_e rot;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(logic [1:0] size_code, logic [1:0] rot);
        ctrl_t c;
        c.undef = ~size_code[1];
        c.wide  = size_code[0];
        c.rot   = rot_e'(rot);
        return c;
    endfunction

    function automatic logic rot_subtracts(rot_e r);
        return r[0] == r[1];
    endfunction

endpackage

// File: rtl/cdot_rotsel.sv
module cdot_rotsel #(
    parameter int unsigned EW = 8
) (
    input  logic [2*EW-1:0]      pair,
    input  cdot_pkg::rot_e       rot,
    output logic signed [EW-1:0] term_a,
    output logic signed [EW-1:0] term_b
);
    logic [EW-1:0] even_e, odd_e;

    assign even_e = pair[EW-1:0];
    assign odd_e  = pair[2*EW-1:EW];

    always_comb begin
        if (rot[0]) begin
            term_a = odd_e;
            term_b = even_e;
        end else begin
            term_a = even_e;
            term_b = odd_e;
        end
    end
endmodule

// File: rtl/cdot_lane.sv
module cdot_lane #(
    parameter int unsigned EW = 8
) (
    input  cdot_pkg::rot_e   rot,
    input  logic [4*EW-1:0]  src_n,
    input  logic [4*EW-1:0]  src_m,
    input  logic [4*EW-1:0]  acc_i,
    output logic [4*EW-1:0]  acc_o
);
    localparam int unsigned LW = 4 * EW;
    localparam int unsigned PW = 2 * EW;

    logic sub_im;
    logic [LW-1:0] stage [3];

    assign sub_im   = cdot_pkg::rot_subtracts(rot);
    assign stage[0] = acc_i;

    for (genvar p = 0; p < 2; p++) begin : g_pair
        logic signed [EW-1:0] re_e, im_e, t_a, t_b;
        logic signed [PW-1:0] prod_a, prod_b;
        logic [LW-1:0] ext_a, ext_b;

        assign re_e = src_n[(2*p)*EW +: EW];
        assign im_e = src_n[(2*p+1)*EW +: EW];

        cdot_rotsel #(.EW(EW)) u_sel (
            .pair   (src_m[p*PW +: PW]),
            .rot    (rot),
            .term_a (t_a),
            .term_b (t_b)
        );

        assign prod_a = re_e * t_a;
        assign prod_b = im_e * t_b;
        assign ext_a  = {{(LW-PW){prod_a[PW-1]}}, prod_a};
        assign ext_b  = {{(LW-PW){prod_b[PW-1]}}, prod_b};

        assign stage[p+1] = sub_im ? (stage[p] + ext_a - ext_b)
                                   : (stage[p] + ext_a + ext_b);
    end

    assign acc_o = stage[2];

    // R3
    always_comb begin
        if (src_m == '0) begin
            zero_term_chk: assert (acc_o == acc_i);
        end
    end
endmodule

// File: rtl/cdot_accum.sv
module cdot_accum #(
    parameter int unsigned VW = cdot_pkg::VEC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [1:0]    size_code,
    input  logic [1:0]    rot,
    input  logic [VW-1:0] src_n,
    input  logic [VW-1:0] src_m,
    input  logic [VW-1:0] acc_in,
    output logic          out_valid,
    output logic          out_undef,
    output logic [VW-1:0] acc_out
);
    import cdot_pkg::*;

    localparam int unsigned NLW = 4 * NARROW_E;
    localparam int unsigned WLW = 4 * WIDE_E;
    localparam int unsigned NL  = VW / NLW;
    localparam int unsigned WL  = VW / WLW;

    ctrl_t         ctrl;
    logic [VW-1:0] res_narrow, res_wide, res_next;

    assign ctrl = decode_ctrl(size_code, rot);

    for (genvar k = 0; k < NL; k++) begin : g_narrow
        cdot_lane #(.EW(NARROW_E)) u_lane (
            .rot   (ctrl.rot),
            .src_n (src_n[k*NLW +: NLW]),
            .src_m (src_m[k*NLW +: NLW]),
            .acc_i (acc_in[k*NLW +: NLW]),
            .acc_o (res_narrow[k*NLW +: NLW])
        );
    end

    for (genvar k = 0; k < WL; k++) begin : g_wide
        cdot_lane #(.EW(WIDE_E)) u_lane (
            .rot   (ctrl.rot),
            .src_n (src_n[k*WLW +: WLW]),
            .src_m (src_m[k*WLW +: WLW]),
            .acc_i (acc_in[k*WLW +: WLW]),
            .acc_o (res_wide[k*WLW +: WLW])
        );
    end

    always_comb begin
        if (ctrl.undef)     res_next = acc_in;
        else if (ctrl.wide) res_next = res_wide;
        else                res_next = res_narrow;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_undef <= 1'b0;
            acc_out   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_undef <= ctrl.undef;
                acc_out   <= res_next;
            end
        end
    end

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(acc_out) && $stable(out_undef)));

    // R7
    undef_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !size_code[1]) |=> (out_undef && acc_out == $past(acc_in)));

    // R7
    undef_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && size_code[1]) |=> !out_undef);
endmodule

// File: tb/tb_cdot_accum.sv
module tb_cdot_accum;
    localparam int VW = 128;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [1:0]    size_code = 2'b00;
    logic [1:0]    rot = 2'b00;
    logic [VW-1:0] src_n = '0, src_m = '0, acc_in = '0;
    logic          out_valid, out_undef;
    logic [VW-1:0] acc_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    cdot_accum #(.VW(VW)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .size_code(size_code),
        .rot(rot), .src_n(src_n), .src_m(src_m), .acc_in(acc_in),
        .out_valid(out_valid), .out_undef(out_undef), .acc_out(acc_out)
    );

    function automatic longint elem(logic [VW-1:0] v, int idx, int ew);
        if (ew == 8) return longint'($signed(v[idx*8 +: 8]));
        return longint'($signed(v[idx*16 +: 16]));
    endfunction

    function automatic logic [VW-1:0] ref_model(logic [1:0] sz, logic [1:0] rt,
            logic [VW-1:0] a, logic [VW-1:0] b, logic [VW-1:0] c);
        logic [VW-1:0] r;
        int ew, lw;
        r = c;
        if (!sz[1]) return r;
        ew = sz[0] ? 16 : 8;
        lw = 4 * ew;
        for (int l = 0; l < VW / lw; l++) begin
            longint acc;
            acc = (lw == 64) ? longint'(c[l*64 +: 64]) : longint'(c[l*32 +: 32]);
            for (int p = 0; p < 2; p++) begin
                longint re, im, ta, tb;
                re = elem(a, 4*l + 2*p, ew);
                im = elem(a, 4*l + 2*p + 1, ew);
                ta = elem(b, 4*l + 2*p + (rt[0] ? 1 : 0), ew);
                tb = elem(b, 4*l + 2*p + (rt[0] ? 0 : 1), ew);
                if (rt[0] == rt[1]) acc = acc + re*ta - im*tb;
                else                acc = acc + re*ta + im*tb;
            end
            if (lw == 64) r[l*64 +: 64] = acc[63:0];
            else          r[l*32 +: 32] = acc[31:0];
        end
        return r;
    endfunction

    task automatic check(bit ok, string req, logic [VW-1:0] act, logic [VW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(logic [1:0] sz, logic [1:0] rt, logic [VW-1:0] a,
            logic [VW-1:0] b, logic [VW-1:0] c, string req);
        logic [VW-1:0] exp;
        exp = ref_model(sz, rt, a, b, c);
        @(negedge clk);
        size_code = sz; rot = rt; src_n = a; src_m = b; acc_in = c; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, "R8 out_valid", VW'(out_valid), VW'(1));
        check(out_undef == !sz[1], "R7 out_undef", VW'(out_undef), VW'(!sz[1]));
        check(acc_out == exp, req, acc_out, exp);
    endtask

    function automatic logic [VW-1:0] rnd_vec();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [VW-1:0] held, e1;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R9: reset state
        check(out_valid == 1'b0, "R9 reset out_valid", VW'(out_valid), '0);
        check(out_undef == 1'b0, "R9 reset out_undef", VW'(out_undef), '0);
        check(acc_out == '0, "R9 reset acc_out", acc_out, '0);
        rst = 1'b0;

        // R1/R2: simple 8-bit lane 0, rot 0: (1+2i)*(3+4i) real = 3-8 = -5
        e1 = '0; e1[31:0] = 32'hFFFF_FFFB;
        issue(2'b10, 2'b00, VW'(32'h0000_0201), VW'(32'h0000_0403), '0, "R1 R2 narrow real");
        check(acc_out == e1, "R1 directed value", acc_out, e1);
        // R1: same bytes in 16-bit mode give a different lane layout
        issue(2'b11, 2'b00, VW'(64'h0002_0001), VW'(64'h0004_0003), '0, "R1 wide real");
        // R3/R4: all rotations, both sizes
        for (int r = 0; r < 4; r++) begin
            issue(2'b10, 2'(r), rnd_vec(), rnd_vec(), rnd_vec(), "R3 R4 narrow rotation");
            issue(2'b11, 2'(r), rnd_vec(), rnd_vec(), rnd_vec(), "R3 R4 wide rotation");
        end
        // R6: extreme values, wrap
        for (int r = 0; r < 4; r++) begin
            issue(2'b10, 2'(r), {16{8'h80}}, {16{8'h80}}, {4{32'h7FFF_FFFF}}, "R6 narrow extremes");
            issue(2'b11, 2'(r), {8{16'h8000}}, {8{16'h8000}}, {2{64'h7FFF_FFFF_FFFF_FFFF}}, "R6 wide extremes");
        end
        // R5: pair order with both pairs nonzero, nonzero accumulator
        issue(2'b10, 2'b01, {4{32'h7F80_017F}}, {4{32'h8001_7F80}}, {4{32'h8000_0000}}, "R5 two pairs");
        // R7: undefined codes pass accumulator
        issue(2'b00, 2'b01, rnd_vec(), rnd_vec(), rnd_vec(), "R7 undefined 00");
        issue(2'b01, 2'b11, rnd_vec(), rnd_vec(), rnd_vec(), "R7 undefined 01");
        // R8: idle cycles hold result
        held = acc_out;
        @(negedge clk);
        size_code = 2'b11; src_n = rnd_vec(); src_m = rnd_vec(); acc_in = rnd_vec();
        @(negedge clk);
        check(out_valid == 1'b0, "R8 idle out_valid", VW'(out_valid), '0);
        check(acc_out == held, "R8 idle hold", acc_out, held);
        // random mix
        for (int n = 0; n < 400; n++) begin
            issue(2'($urandom), 2'($urandom), rnd_vec(), rnd_vec(), rnd_vec(), "R1 R3 R4 R6 random");
        end
        // R9: reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && acc_out == '0, "R9 reset again", acc_out, '0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule